// File: doc/BRIEF.md
# Four-Line Time-Sliced Memory Reader

This block feeds a four-tap vertical interpolator with one pixel from each of four video lines in every output pixel period. It runs on a memory clock at four times the pixel rate. The pixel rate is marked by a one-cycle pixel strobe. All four lines are read through a single synchronous-read memory port. The four reads are cut into four time slots, one per line, in a fixed order. Because every reader is on the same clock and the slots never move, no arbitration is needed, and moving from one line to the next costs no extra cycles.

Each memory word packs several pixels, four 8-bit pixels in a 32-bit word by default. The block keeps the last word it fetched for each line, along with that word's address. It goes to memory only when a line needs a word it does not already hold. Across a run of pixels, each line is therefore read once every fourth pixel. After the fourth slot, the block picks the requested pixel out of each held word and presents all four pixels together with a one-cycle valid pulse. The interpolation arithmetic and the memory writer are outside this block. The block assumes that memory contents do not change under a word it is holding.

Top module: `blockram_line_reader`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `tap_valid` is 0, `tap_pix` is all zeros and `mem_rd` is 0.
- R2: After a strobe, the memory address in the four following cycles serves taps 0, 1, 2, 3 in that order. Tap k is read at `line_base[k] + pix_idx/4`, where tap k's base occupies bits `k*12 +: 12` of `line_base`.
- R3: `tap_valid` is high for exactly one cycle, six clock cycles after the edge that samples the strobe.
- R4: Tap k of `tap_pix` (bits `k*8 +: 8`) equals pixel `pix_idx mod 4` of the word at tap k's address. Pixel 0 is the least-significant byte (bits 7:0) and pixel 3 is bits 31:24.
- R5: A tap reads memory in its slot only when its word address differs from the last word fetched for that tap. Pixels that fall in an already-held word cause no read, and changing only one line's base causes exactly one read.
- R6: Strobes may arrive every fourth cycle. Each one yields its own result, in order, with no result lost.
- R7: `tap_pix` does not change except in the cycle in which `tap_valid` is high.
- R8: With no strobe pending, `mem_rd` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock, four times the pixel rate |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_stb | input | 1 | Pixel strobe; at most once every four cycles |
| line_base | input | 48 | Four 12-bit word addresses, one per line; tap k at bits k*12 +: 12 |
| pix_idx | input | 10 | Pixel index within the lines |
| mem_rd | output | 1 | Memory read enable |
| mem_addr | output | 12 | Memory word address |
| mem_rdata | input | 32 | Memory read data, valid one cycle after mem_rd |
| tap_pix | output | 32 | Four aligned pixels; tap k at bits k*8 +: 8 |
| tap_valid | output | 1 | One-cycle pulse marking a new set of taps |

## Verification
The four addresses for a strobe appear in the first to fourth cycles after the edge that samples it, and the taps appear six cycles after that edge. The bench drives inputs on falling edges. It reads the address on the four falling edges that follow the strobe. It expects `tap_valid` low on the sixth falling edge after the drive, high on the seventh and low again on the eighth. A monitor compares every valid pulse against a queue of expected values, so back-to-back strobes are matched in order. Read counts are taken only after a gap of eight cycles, once all four slots have finished.

// File: rtl/lr_pkg.sv
// Shared constants for the four-line reader.
package lr_pkg;
    localparam int NTAP   = 4;  // lines served per pixel period
    localparam int SLOT_W = 2;  // width of the slot counter
endpackage

// File: rtl/lr_slot_seq.sv
// Slot sequencer. On a pixel strobe it latches the four line bases and
// the pixel index. It then steps a 2-bit slot through taps 0..3 and
// presents each tap's word address in turn.
// Assumes strobes are at least NTAP cycles apart.
module lr_slot_seq
    import lr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 10,
    parameter int LANE_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pix_stb,
    input  logic [NTAP*ADDR_W-1:0]   line_base,
    input  logic [IDX_W-1:0]         pix_idx,
    output logic                     slot_act,
    output logic [SLOT_W-1:0]        slot,
    output logic [ADDR_W-1:0]        req_addr,
    output logic [LANE_W-1:0]        req_lane
);
    localparam int WIDX_W = IDX_W - LANE_W;

    logic [ADDR_W-1:0] base_q [NTAP];
    logic [WIDX_W-1:0] word_q;

    // Latch a request on the strobe, otherwise advance through the slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_act <= 1'b0;
            slot     <= '0;
            word_q   <= '0;
            req_lane <= '0;
            for (int k = 0; k < NTAP; k++) base_q[k] <= '0;
        end else if (pix_stb) begin
            slot_act <= 1'b1;
            slot     <= '0;
            word_q   <= pix_idx[IDX_W-1:LANE_W];
            req_lane <= pix_idx[LANE_W-1:0];
            for (int k = 0; k < NTAP; k++) base_q[k] <= line_base[k*ADDR_W +: ADDR_W];
        end else if (slot_act) begin
            if (slot == SLOT_W'(NTAP-1)) slot_act <= 1'b0;
            slot <= slot + 1'b1;
        end
    end

    // Word address of the tap that owns the current slot.
    always_comb req_addr = base_q[slot] + ADDR_W'(word_q);
endmodule

// File: rtl/lr_word_hold.sv
// Per-tap word holder. Each tap keeps the last word fetched for it,
// with that word's address. It issues a memory read only when the slot
// asks for a different word. Memory read latency is one cycle.
// Assumes memory is not rewritten under a held word.
module lr_word_hold
    import lr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int WORD_W = 32,
    parameter int LANE_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     slot_act,
    input  logic [SLOT_W-1:0]        slot,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [LANE_W-1:0]        req_lane,
    output logic                     mem_rd,
    output logic [ADDR_W-1:0]        mem_addr,
    input  logic [WORD_W-1:0]        mem_rdata,
    output logic [NTAP*WORD_W-1:0]   words,
    output logic                     done,
    output logic [LANE_W-1:0]        done_lane
);
    logic [ADDR_W-1:0] held_addr [NTAP];
    logic [WORD_W-1:0] held_word [NTAP];
    logic [NTAP-1:0]   held_ok;
    logic              fetch_d, act_d;
    logic [SLOT_W-1:0] slot_d;
    logic [LANE_W-1:0] lane_d;

    // Read only when this tap's held word is missing or stale.
    always_comb begin
        mem_rd   = slot_act && (!held_ok[slot] || held_addr[slot] != req_addr);
        mem_addr = req_addr;
    end

    // Track the fetched addresses, store returning data and flag slot 3.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_ok   <= '0;
            fetch_d   <= 1'b0;
            act_d     <= 1'b0;
            slot_d    <= '0;
            lane_d    <= '0;
            done      <= 1'b0;
            done_lane <= '0;
            for (int k = 0; k < NTAP; k++) begin
                held_addr[k] <= '0;
                held_word[k] <= '0;
            end
        end else begin
            fetch_d   <= mem_rd;
            act_d     <= slot_act;
            slot_d    <= slot;
            lane_d    <= req_lane;
            done      <= act_d && (slot_d == SLOT_W'(NTAP-1));
            done_lane <= lane_d;
            if (mem_rd) begin
                held_addr[slot] <= req_addr;
                held_ok[slot]   <= 1'b1;
            end
            if (fetch_d) held_word[slot_d] <= mem_rdata;
        end
    end

    generate
        for (genvar k = 0; k < NTAP; k++) begin : g_words
            assign words[k*WORD_W +: WORD_W] = held_word[k];
        end
    endgenerate
endmodule

// File: rtl/lr_unpack.sv
// Output aligner. When all four slots are complete, it selects the same
// pixel lane from each held word and registers the four pixels together.
// Lane 0 is the least-significant pixel.
module lr_unpack
    import lr_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int PPW    = 4,
    parameter int LANE_W = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        done,
    input  logic [LANE_W-1:0]           done_lane,
    input  logic [NTAP*PIX_W*PPW-1:0]   words,
    output logic [NTAP*PIX_W-1:0]       tap_pix,
    output logic                        tap_valid
);
    localparam int WORD_W = PIX_W * PPW;

    logic [NTAP*PIX_W-1:0] sel;

    generate
        for (genvar k = 0; k < NTAP; k++) begin : g_sel
            assign sel[k*PIX_W +: PIX_W] =
                words[k*WORD_W + int'(done_lane)*PIX_W +: PIX_W];
        end
    endgenerate

    // Update all taps at once and pulse the valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap_pix   <= '0;
            tap_valid <= 1'b0;
        end else begin
            tap_valid <= done;
            if (done) tap_pix <= sel;
        end
    end
endmodule

// File: rtl/blockram_line_reader.sv
// Top level. It serves four line readers from one synchronous-read memory
// port by giving each line one slot of a four-cycle rotation. Words hold
// PPW pixels. The result follows the strobe by six cycles.
// Assumes PPW is a power of two, at least 2.
module blockram_line_reader
    import lr_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int PPW    = 4,
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pix_stb,
    input  logic [NTAP*ADDR_W-1:0]   line_base,
    input  logic [IDX_W-1:0]         pix_idx,
    output logic                     mem_rd,
    output logic [ADDR_W-1:0]        mem_addr,
    input  logic [PIX_W*PPW-1:0]     mem_rdata,
    output logic [NTAP*PIX_W-1:0]    tap_pix,
    output logic                     tap_valid
);
    localparam int WORD_W = PIX_W * PPW;
    localparam int LANE_W = $clog2(PPW);

    logic                    slot_act;
    logic [SLOT_W-1:0]       slot;
    logic [ADDR_W-1:0]       req_addr;
    logic [LANE_W-1:0]       req_lane;
    logic [NTAP*WORD_W-1:0]  words;
    logic                    done;
    logic [LANE_W-1:0]       done_lane;

    lr_slot_seq #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .LANE_W(LANE_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .pix_stb(pix_stb), .line_base(line_base),
        .pix_idx(pix_idx), .slot_act(slot_act), .slot(slot),
        .req_addr(req_addr), .req_lane(req_lane)
    );

    lr_word_hold #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LANE_W(LANE_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .slot_act(slot_act), .slot(slot),
        .req_addr(req_addr), .req_lane(req_lane), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .words(words),
        .done(done), .done_lane(done_lane)
    );

    lr_unpack #(.PIX_W(PIX_W), .PPW(PPW), .LANE_W(LANE_W)) u_unpack (
        .clk(clk), .rst_n(rst_n), .done(done), .done_lane(done_lane),
        .words(words), .tap_pix(tap_pix), .tap_valid(tap_valid)
    );
endmodule

// File: rtl/lr_checker.sv
// Protocol checker for blockram_line_reader. It keeps its own history of
// strobes and its own copy of the latched request, and checks the slot
// order, the result latency and the output hold.
module lr_checker
    import lr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 10,
    parameter int PPW    = 4,
    parameter int TAP_W  = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    pix_stb,
    input logic [NTAP*ADDR_W-1:0]  line_base,
    input logic [IDX_W-1:0]        pix_idx,
    input logic                    mem_rd,
    input logic [ADDR_W-1:0]       mem_addr,
    input logic [TAP_W-1:0]        tap_pix,
    input logic                    tap_valid
);
    localparam int LANE_W = $clog2(PPW);

    logic [6:0]        hist;
    logic [ADDR_W-1:0] cb [NTAP];
    logic [ADDR_W-1:0] cw;

    // Record the strobe history and the request each strobe carried.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
            cw   <= '0;
            for (int k = 0; k < NTAP; k++) cb[k] <= '0;
        end else begin
            hist <= {hist[5:0], pix_stb};
            if (pix_stb) begin
                cw <= ADDR_W'(pix_idx >> LANE_W);
                for (int k = 0; k < NTAP; k++) cb[k] <= line_base[k*ADDR_W +: ADDR_W];
            end
        end
    end

    AST_STB_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        pix_stb |-> !(|hist[2:0]));                                     // R6
    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        tap_valid == hist[6]);                                          // R3
    AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (|hist[3:0]));                                       // R8
    AST_TAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tap_valid |-> $stable(tap_pix));                               // R7

    generate
        for (genvar k = 0; k < NTAP; k++) begin : g_slot
            AST_SLOT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
                (mem_rd && hist[k]) |-> mem_addr == cb[k] + cw);        // R2
        end
    endgenerate
endmodule

bind blockram_line_reader lr_checker #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .PPW(PPW), .TAP_W(NTAP*PIX_W)
) u_lr_checker (
    .clk(clk), .rst_n(rst_n), .pix_stb(pix_stb), .line_base(line_base),
    .pix_idx(pix_idx), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .tap_pix(tap_pix), .tap_valid(tap_valid)
);

// File: tb/blockram_line_reader_test.sv
// Directed bench: one task per scenario, with a memory model and a
// monitor that checks every result against a queue of expected taps.
module blockram_line_reader_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_stb = 1'b0;
    logic [47:0] line_base = '0;
    logic [9:0]  pix_idx = '0;
    logic        mem_rd;
    logic [11:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic [31:0] tap_pix;
    logic        tap_valid;

    int checks = 0, errors = 0, reads = 0, valids = 0;
    logic [31:0] expq [64];
    int wr_p = 0, rd_p = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    blockram_line_reader uut (
        .clk(clk), .rst_n(rst_n), .pix_stb(pix_stb), .line_base(line_base),
        .pix_idx(pix_idx), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .tap_pix(tap_pix), .tap_valid(tap_valid)
    );

    function automatic logic [31:0] word_at(input logic [11:0] a);
        return {a[7:0] ^ 8'hC3, a[7:0] + 8'h11, ~a[7:0], a[7:0] ^ {a[11:8], 4'h5}};
    endfunction

    function automatic logic [31:0] expect_taps(input logic [47:0] b, input logic [9:0] idx);
        logic [31:0] r;
        for (int k = 0; k < 4; k++) begin
            logic [31:0] w;
            w = word_at(b[k*12 +: 12] + 12'(idx >> 2));
            r[k*8 +: 8] = w[int'(idx[1:0])*8 +: 8];
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Memory model: one-cycle synchronous read.
    always @(posedge clk) if (mem_rd) mem_rdata <= word_at(mem_addr);

    // Count reads and check every result in order (R4, R6).
    always @(negedge clk) begin
        if (rst_n && mem_rd) reads++;
        if (rst_n && tap_valid) begin
            valids++;
            check("R4/R6 taps", tap_pix, expq[rd_p % 64]);
            rd_p++;
        end
    end

    // Drive one strobe at a falling edge; return 'gap' falling edges later.
    task automatic issue(input logic [47:0] b, input logic [9:0] idx, input int gap);
        pix_stb = 1'b1; line_base = b; pix_idx = idx;
        expq[wr_p % 64] = expect_taps(b, idx); wr_p++;
        @(negedge clk); pix_stb = 1'b0;
        repeat (gap - 1) @(negedge clk);
    endtask

    function automatic logic [47:0] bases(input int a, input int b, input int c, input int d);
        return {12'(d), 12'(c), 12'(b), 12'(a)};
    endfunction

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check("R1 valid", {31'b0, tap_valid}, 32'd0);
        check("R1 taps", tap_pix, 32'd0);
        check("R1 rd", {31'b0, mem_rd}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after release", {31'b0, tap_valid}, 32'd0);
        check("R1 rd after release", {31'b0, mem_rd}, 32'd0);
    endtask

    task automatic t_order_latency;
        logic [47:0] b;
        logic [11:0] got [4];
        logic v6, v7, v8;
        b = bases(16, 530, 1040, 2050);
        pix_stb = 1'b1; line_base = b; pix_idx = 10'd37;
        expq[wr_p % 64] = expect_taps(b, 10'd37); wr_p++;
        for (int n = 1; n <= 8; n++) begin
            @(negedge clk);
            if (n == 1) pix_stb = 1'b0;
            if (n <= 4) got[n-1] = mem_addr;
            if (n == 6) v6 = tap_valid;
            if (n == 7) v7 = tap_valid;
            if (n == 8) v8 = tap_valid;
        end
        for (int k = 0; k < 4; k++)
            check("R2 slot address", {20'b0, got[k]}, {20'b0, b[k*12 +: 12] + 12'd9});
        check("R3 low before", {31'b0, v6}, 32'd0);
        check("R3 high on time", {31'b0, v7}, 32'd1);
        check("R3 one cycle", {31'b0, v8}, 32'd0);
    endtask

    task automatic t_lanes;
        for (int l = 0; l < 4; l++) issue(bases(100, 200, 300, 400), 10'(64 + l), 8);   // R4
    endtask

    task automatic t_reuse;
        int r0;
        logic [47:0] b;
        b = bases(700, 800, 900, 1000);
        r0 = reads; issue(b, 10'd8, 8);
        check("R5 first word reads", 32'(reads - r0), 32'd4);
        r0 = reads; issue(b, 10'd9, 8); issue(b, 10'd10, 8); issue(b, 10'd11, 8);
        check("R5 held word no reads", 32'(reads - r0), 32'd0);
        r0 = reads; issue(b, 10'd12, 8);
        check("R5 next word reads", 32'(reads - r0), 32'd4);
        r0 = reads; issue(bases(700, 800, 910, 1000), 10'd12, 8);
        check("R5 one line changed", 32'(reads - r0), 32'd1);
    endtask

    task automatic t_back_to_back;
        int v0;
        v0 = valids;
        for (int i = 0; i < 8; i++) issue(bases(1200 + i, 1500, 1800 - i, 2100), 10'(250 + i), 4);
        repeat (8) @(negedge clk);
        check("R6 result count", 32'(valids - v0), 32'd8);
        check("R6 queue drained", 32'(wr_p - rd_p), 32'd0);
    endtask

    task automatic t_hold_idle;
        logic [31:0] snap;
        int r0;
        bit moved, pulsed;
        snap = tap_pix; r0 = reads; moved = 0; pulsed = 0;
        repeat (20) begin
            @(negedge clk);
            if (tap_pix !== snap) moved = 1;
            if (tap_valid) pulsed = 1;
        end
        check("R7 taps held", {31'b0, moved}, 32'd0);
        check("R7 no pulse", {31'b0, pulsed}, 32'd0);
        check("R8 no idle reads", 32'(reads - r0), 32'd0);
    endtask

    initial begin
        t_reset;
        t_order_latency;
        t_lanes;
        t_reuse;
        t_back_to_back;
        t_hold_idle;
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule